// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Flag Generator

This block produces the two early-warning flags of a dual-clock FIFO. It does not track pointers. The FIFO core gives it two values: the occupancy as seen in the read clock domain, and the occupancy as seen in the write clock domain. From these it raises an active-low almost-empty flag, owned only by the read clock, and an active-low almost-full flag, owned only by the write clock.

Each flag has its own threshold register, held in that flag's clock domain. An external configuration block loads a new threshold through a one-cycle load strobe and a value bus. A threshold may be any word count from 0 up to the FIFO depth. After reset, both thresholds are seven words: almost-empty fires at seven or fewer stored words, and almost-full fires at seven or fewer free words. Both flags are registered, so a new value stays on the pin for at least one full cycle of its own clock.

Top module: `pflag_gen`

## Requirements
- R1: While `rd_rst` is high, `ae_n` reads 0 after each `rd_clk` edge. While `wr_rst` is high, `af_n` reads 1 after each `wr_clk` edge.
- R2: Outside reset, after each rising edge of `rd_clk`, `ae_n` equals 0 when the `rd_count` sampled at that edge is less than or equal to the current empty threshold, and 1 otherwise.
- R3: Outside reset, after each rising edge of `wr_clk`, `af_n` equals 0 when DEPTH minus the sampled `wr_count` is less than or equal to the current full threshold, and 1 otherwise.
- R4: Reset sets both thresholds to 7 words. With no load after reset, `ae_n` is 0 for `rd_count` of 7 and 1 for a count of 8. `af_n` is 0 for a `wr_count` of DEPTH-7 and 1 for DEPTH-8.
- R5: An edge of `rd_clk` that sees `ae_ld` high stores `ae_off` as the empty threshold. The comparison at that same edge still uses the old threshold. The new threshold governs from the next edge on.
- R6: An edge of `wr_clk` that sees `af_ld` high stores `af_off` as the full threshold. It uses the same timing as the empty side.
- R7: `ae_n` changes only at rising edges of `rd_clk`, and `af_n` changes only at rising edges of `wr_clk`.
- R8: Thresholds have one-word resolution over the full range 0 to DEPTH. With a threshold of 0, a flag fires only at completely empty or completely full. With a threshold of DEPTH, the flag is always asserted.
- R9: A load strobe seen while its domain is in reset is ignored. The threshold after reset is still the default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_count | input | CW | Words stored, as seen in the read domain (0..DEPTH) |
| ae_ld | input | 1 | Load strobe for the empty threshold |
| ae_off | input | CW | New empty threshold in words |
| ae_n | output | 1 | Almost-empty flag, active low |
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_count | input | CW | Words stored, as seen in the write domain (0..DEPTH) |
| af_ld | input | 1 | Load strobe for the full threshold |
| af_off | input | CW | New full threshold in words |
| af_n | output | 1 | Almost-full flag, active low |

## Verification
The state inside this block is the two threshold registers and the two flag registers. A wrong threshold has no effect while occupancy stays far from it. It shows on the flag at the first `rd_clk` or `wr_clk` edge after the count crosses between the true and the wrong threshold. For this reason the bench sweeps counts across each loaded threshold and across the default value of 7. A flag register with wrong reset polarity, or updated by the wrong clock, shows within one edge of its own clock. This is because the reference model checks every flag after every edge of its domain, and the bench checks every flag transition against the time of its domain's last edge.

// File: rtl/pflag_pkg.sv
package pflag_pkg;
  typedef enum logic {
    LVL_STORED = 1'b0,
    LVL_FREE   = 1'b1
  } lvl_kind_e;
endpackage

// File: rtl/pflag_level.sv
module pflag_level
  import pflag_pkg::*;
#(
  parameter lvl_kind_e KIND  = LVL_STORED,
  parameter int        DEPTH = 64,
  localparam int       CW    = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] count,
  output logic [CW-1:0] level
);
  generate
    if (KIND == LVL_FREE) begin : g_free
      always_comb level = CW'(DEPTH) - count;
    end else begin : g_stored
      always_comb level = count;
    end
  endgenerate
endmodule

// File: rtl/pflag_thresh.sv
module pflag_thresh #(
  parameter int   CW      = 7,
  parameter int   DEF_THR = 7,
  parameter logic RST_FLG = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] level,
  input  logic          ld,
  input  logic [CW-1:0] off,
  output logic          flag_n
);
  logic [CW-1:0] thr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q  <= CW'(DEF_THR);
      flag_n <= RST_FLG;
    end else begin
      flag_n <= !(level <= thr_q);
      if (ld) thr_q <= off;
    end
  end

  // R5 R6
  thr_load_chk: assert property (@(posedge clk) disable iff (rst)
    ld |=> (thr_q == $past(off)));

  // R2 R3
  flag_on_chk: assert property (@(posedge clk) disable iff (rst)
    (level <= thr_q) |=> !flag_n);

  // R2 R3
  flag_off_chk: assert property (@(posedge clk) disable iff (rst)
    (level > thr_q) |=> flag_n);

  // R8
  thr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(thr_q));
endmodule

// File: rtl/pflag_gen.sv
module pflag_gen
  import pflag_pkg::*;
#(
  parameter int  DEPTH     = 64,
  parameter int  DEF_EMPTY = 7,
  parameter int  DEF_FULL  = 7,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic [CW-1:0] rd_count,
  input  logic          ae_ld,
  input  logic [CW-1:0] ae_off,
  output logic          ae_n,
  input  logic          wr_clk,
  input  logic          wr_rst,
  input  logic [CW-1:0] wr_count,
  input  logic          af_ld,
  input  logic [CW-1:0] af_off,
  output logic          af_n
);
  logic [CW-1:0] stored_lvl;
  logic [CW-1:0] free_lvl;

  pflag_level #(.KIND(LVL_STORED), .DEPTH(DEPTH)) u_stored (
    .count(rd_count), .level(stored_lvl)
  );

  pflag_level #(.KIND(LVL_FREE), .DEPTH(DEPTH)) u_free (
    .count(wr_count), .level(free_lvl)
  );

  pflag_thresh #(.CW(CW), .DEF_THR(DEF_EMPTY), .RST_FLG(1'b0)) u_ae (
    .clk(rd_clk), .rst(rd_rst), .level(stored_lvl),
    .ld(ae_ld), .off(ae_off), .flag_n(ae_n)
  );

  pflag_thresh #(.CW(CW), .DEF_THR(DEF_FULL), .RST_FLG(1'b1)) u_af (
    .clk(wr_clk), .rst(wr_rst), .level(free_lvl),
    .ld(af_ld), .off(af_off), .flag_n(af_n)
  );

  // R8
  empty_hit_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_count == '0) |=> !ae_n);

  // R8
  full_hit_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_count == CW'(DEPTH)) |=> !af_n);

  // R1
  ae_rst_chk: assert property (@(posedge rd_clk)
    rd_rst |=> !ae_n);

  // R1
  af_rst_chk: assert property (@(posedge wr_clk)
    wr_rst |=> af_n);
endmodule

// File: tb/test_pflag_gen.sv
module test_pflag_gen;
  localparam int  DEPTH      = 64;
  localparam int  CW         = $clog2(DEPTH + 1);
  localparam time CLK_PERIOD = 10;
  localparam time WR_PERIOD  = 14;

  logic          rd_clk = 0, wr_clk = 0;
  logic          rd_rst = 1, wr_rst = 1;
  logic [CW-1:0] rd_count = '0, wr_count = '0;
  logic          ae_ld = 0, af_ld = 0;
  logic [CW-1:0] ae_off = '0, af_off = '0;
  logic          ae_n, af_n;

  int errors = 0, checks = 0;
  string ae_tag = "R1", af_tag = "R1";
  int m_ae_thr = 7, m_af_thr = 7;
  logic m_ae = 0, m_af = 1;
  time t_rd = 0, t_wr = 0;
  bit  finished = 0;

  pflag_gen #(.DEPTH(DEPTH)) i_pflag_gen (
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_count(rd_count),
    .ae_ld(ae_ld), .ae_off(ae_off), .ae_n(ae_n),
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_count(wr_count),
    .af_ld(af_ld), .af_off(af_off), .af_n(af_n)
  );

  always #(CLK_PERIOD/2) rd_clk = ~rd_clk;
  always #(WR_PERIOD/2)  wr_clk = ~wr_clk;

  // reference model, read domain
  always @(posedge rd_clk) begin
    t_rd = $time;
    if (rd_rst) begin
      m_ae_thr = 7; m_ae = 0;
    end else begin
      m_ae = !(int'(rd_count) <= m_ae_thr);
      if (ae_ld) m_ae_thr = int'(ae_off);
    end
  end

  // reference model, write domain
  always @(posedge wr_clk) begin
    t_wr = $time;
    if (wr_rst) begin
      m_af_thr = 7; m_af = 1;
    end else begin
      m_af = !((DEPTH - int'(wr_count)) <= m_af_thr);
      if (af_ld) m_af_thr = int'(af_off);
    end
  end

  always @(negedge rd_clk) if (!finished) begin
    checks++;
    if (ae_n !== m_ae) begin
      errors++;
      $display("FAIL %s ae_n actual=%b expected=%b count=%0d", ae_tag, ae_n, m_ae, rd_count);
    end
  end

  always @(negedge wr_clk) if (!finished) begin
    checks++;
    if (af_n !== m_af) begin
      errors++;
      $display("FAIL %s af_n actual=%b expected=%b count=%0d", af_tag, af_n, m_af, wr_count);
    end
  end

  // R7: flags move only at their own clock edge
  always @(ae_n) if ($time > 0 && !finished) begin
    checks++;
    if ($time != t_rd) begin
      errors++;
      $display("FAIL R7 ae_n changed at %0t actual, expected %0t", $time, t_rd);
    end
  end
  always @(af_n) if ($time > 0 && !finished) begin
    checks++;
    if ($time != t_wr) begin
      errors++;
      $display("FAIL R7 af_n changed at %0t actual, expected %0t", $time, t_wr);
    end
  end

  task automatic rd_step(input int cnt, input bit ld = 0, input int off = 0);
    @(negedge rd_clk);
    rd_count = CW'(cnt); ae_ld = ld; ae_off = CW'(off);
  endtask

  task automatic wr_step(input int cnt, input bit ld = 0, input int off = 0);
    @(negedge wr_clk);
    wr_count = CW'(cnt); af_ld = ld; af_off = CW'(off);
  endtask

  task automatic rd_seq();
    ae_tag = "R9";
    rd_step(3, 1, 30); rd_step(3, 1, 30); rd_step(3, 1, 30);
    @(negedge rd_clk); rd_rst = 0; ae_ld = 0;
    ae_tag = "R4";
    for (int c = 0; c <= 12; c++) rd_step(c);
    for (int c = 12; c >= 0; c--) rd_step(c);
    ae_tag = "R5";
    rd_step(5, 1, 20); rd_step(20); rd_step(21); rd_step(19);
    ae_tag = "R8";
    rd_step(1, 1, 0);
    for (int c = 0; c <= 3; c++) rd_step(c);
    rd_step(40, 1, DEPTH);
    for (int c = DEPTH - 2; c <= DEPTH; c++) rd_step(c);
    ae_tag = "R2";
    for (int i = 0; i < 400; i++)
      rd_step($urandom_range(0, DEPTH), ($urandom_range(0, 15) == 0), $urandom_range(0, DEPTH));
    ae_tag = "R1";
    @(negedge rd_clk); rd_rst = 1; ae_ld = 0;
    rd_step(0); rd_step(0);
    @(negedge rd_clk); rd_rst = 0;
    ae_tag = "R4";
    rd_step(7); rd_step(8); rd_step(8);
  endtask

  task automatic wr_seq();
    af_tag = "R9";
    wr_step(60, 1, 30); wr_step(60, 1, 30); wr_step(60, 1, 30);
    @(negedge wr_clk); wr_rst = 0; af_ld = 0;
    af_tag = "R4";
    for (int c = DEPTH - 12; c <= DEPTH; c++) wr_step(c);
    for (int c = DEPTH; c >= DEPTH - 12; c--) wr_step(c);
    af_tag = "R6";
    wr_step(50, 1, 20); wr_step(DEPTH - 20); wr_step(DEPTH - 21); wr_step(DEPTH - 19);
    af_tag = "R8";
    wr_step(DEPTH - 1, 1, 0);
    for (int c = DEPTH - 3; c <= DEPTH; c++) wr_step(c);
    wr_step(10, 1, DEPTH);
    for (int c = 0; c <= 2; c++) wr_step(c);
    af_tag = "R3";
    for (int i = 0; i < 300; i++)
      wr_step($urandom_range(0, DEPTH), ($urandom_range(0, 15) == 0), $urandom_range(0, DEPTH));
    af_tag = "R1";
    @(negedge wr_clk); wr_rst = 1; af_ld = 0;
    wr_step(DEPTH); wr_step(DEPTH);
    @(negedge wr_clk); wr_rst = 0;
    af_tag = "R4";
    wr_step(DEPTH - 7); wr_step(DEPTH - 8); wr_step(DEPTH - 8);
  endtask

  initial begin
    fork
      rd_seq();
      wr_seq();
    join
    repeat (3) @(negedge wr_clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule